// File: doc/BRIEF.md
# Link Traffic Spy Buffer

This block sits beside one data link and keeps a record of the most recent words that pass on it. It never drives the link and never stalls it. Each valid word is stored in a circular memory at a write pointer that then advances. When the pointer runs past the last entry, it returns to zero and an overflow flag latches. A host can freeze recording, inspect the contents at leisure, clear the buffer and release it again.

The host side has one read port. With the select low, the read returns the memory word at the given address. With the select high, it returns a status word that holds the write pointer (the first free location), the overflow flag and the freeze state. Every read has a fixed latency of one cycle, and no read changes any state. Freeze, release and clear are single-cycle command pulses.

Top module: `spy_buffer_top`

## Requirements
- R1: While reset is asserted and after it is released, the write pointer is 0, overflow is 0, the buffer is not frozen, and `rdValid` and `rdData` are 0.
- R2: When the buffer is not frozen and `linkValid` is high at a clock edge, `linkData` is stored at the current write pointer and the pointer increments by one.
- R3: A capture at location DEPTH-1 returns the pointer to 0 and sets the overflow flag. The flag stays set until a clear command is accepted.
- R4: A `freezeCmd` pulse makes the buffer frozen from the next cycle on. While the buffer is frozen, no word is stored and the pointer holds. A `releaseCmd` pulse unfreezes it, and capture resumes at the held pointer. When both pulses arrive in the same cycle, freeze wins.
- R5: A `clearCmd` pulse while the buffer is frozen sets the pointer to 0 and the overflow flag to 0, and the buffer stays frozen. While the buffer is not frozen, `clearCmd` is ignored.
- R6: A read with `rdSel`=0 returns the memory word at `rdAddr` in the following cycle. If a capture writes that location in the same cycle, the read returns the old word.
- R7: A read with `rdSel`=1 returns, in the following cycle, a status word that reflects the state in the request cycle: bits [ADDR_W-1:0] hold the write pointer, bit DATA_W-2 holds the overflow flag, bit DATA_W-1 holds the frozen flag, and all other bits are 0.
- R8: `rdValid` is high in exactly the cycle after each cycle in which `rdEn` is high. Reads never change the pointer, the overflow flag or the freeze state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkValid | input | 1 | Monitored link word valid |
| linkData | input | DATA_W | Monitored link word |
| freezeCmd | input | 1 | Pulse: stop capture |
| releaseCmd | input | 1 | Pulse: resume capture |
| clearCmd | input | 1 | Pulse: reset pointer and overflow (only while frozen) |
| rdEn | input | 1 | Host read request |
| rdSel | input | 1 | 0 = memory word, 1 = status word |
| rdAddr | input | ADDR_W | Memory location to read |
| rdData | output | DATA_W | Read result, one cycle after the request |
| rdValid | output | 1 | Marks rdData as valid |

## Verification
The assertions check the control state on every cycle: the pointer steps by one on each capture and holds while frozen, the overflow flag sets on wrap and stays sticky, an accepted clear zeroes the pointer and flag, a clear outside freeze leaves the pointer alone, and the freeze flag follows the command pulses with freeze taking priority. Only the bench scenarios can show that the stored words are the right ones, at the right locations, including the case of a read colliding with a write. They also show the exact status word layout, that frozen contents survive live traffic, and that capture resumes at the held pointer after a release.

// File: rtl/spy_pkg.sv
package spy_pkg;

  // Strobes issued by the control block to the datapath each cycle
  typedef struct packed {
    logic capture;  // store linkData at the write pointer
    logic rdMem;    // register a memory word onto rdData
    logic rdStat;   // register the status word onto rdData
  } spyStrobe_t;

endpackage

// File: rtl/spy_ctrl.sv
module spy_ctrl
  import spy_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkValid,
  input  logic              freezeCmd,
  input  logic              releaseCmd,
  input  logic              clearCmd,
  input  logic              rdEn,
  input  logic              rdSel,
  output spyStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrPtr,
  output logic              overflow,
  output logic              frozen,
  output logic              rdValid
);

  localparam logic [ADDR_W-1:0] LAST_LOC = '1;

  logic clearOk;
  logic wrapNow;

  always_comb begin
    strobe.capture = linkValid && !frozen;
    strobe.rdMem   = rdEn && !rdSel;
    strobe.rdStat  = rdEn && rdSel;
    clearOk        = clearCmd && frozen;
    wrapNow        = strobe.capture && (wrPtr == LAST_LOC);
  end

  // Write pointer: clear and capture are exclusive (capture needs !frozen)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (clearOk) begin
      wrPtr <= '0;
    end else if (strobe.capture) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  // Sticky overflow flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (clearOk) begin
      overflow <= 1'b0;
    end else if (wrapNow) begin
      overflow <= 1'b1;
    end
  end

  // Freeze state, freeze has priority over release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frozen <= 1'b0;
    end else if (freezeCmd) begin
      frozen <= 1'b1;
    end else if (releaseCmd) begin
      frozen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
    end
  end

endmodule

// File: rtl/spy_datapath.sv
module spy_datapath
  import spy_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  spyStrobe_t        strobe,
  input  logic [DATA_W-1:0] linkData,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic              overflow,
  input  logic              frozen,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int OVF_BIT = DATA_W - 2;
  localparam int FRZ_BIT = DATA_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] statWord;

  always_comb begin
    statWord             = '0;
    statWord[ADDR_W-1:0] = wrPtr;
    statWord[OVF_BIT]    = overflow;
    statWord[FRZ_BIT]    = frozen;
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      mem[wrPtr] <= linkData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdStat) begin
      rdData <= statWord;
    end else if (strobe.rdMem) begin
      rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/spy_buffer_top.sv
module spy_buffer_top
  import spy_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkValid,
  input  logic [DATA_W-1:0] linkData,
  input  logic              freezeCmd,
  input  logic              releaseCmd,
  input  logic              clearCmd,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  spyStrobe_t        strobe;
  logic [ADDR_W-1:0] wrPtr;
  logic              overflow;
  logic              frozen;

  spy_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .linkValid(linkValid),
    .freezeCmd(freezeCmd), .releaseCmd(releaseCmd), .clearCmd(clearCmd),
    .rdEn(rdEn), .rdSel(rdSel), .strobe(strobe), .wrPtr(wrPtr),
    .overflow(overflow), .frozen(frozen), .rdValid(rdValid)
  );

  spy_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkData(linkData),
    .wrPtr(wrPtr), .overflow(overflow), .frozen(frozen),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/spy_checker.sv
module spy_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              linkValid,
  input logic              freezeCmd,
  input logic              releaseCmd,
  input logic              clearCmd,
  input logic              rdEn,
  input logic [ADDR_W-1:0] wrPtr,
  input logic              overflow,
  input logic              frozen,
  input logic              rdValid
);

  localparam logic [ADDR_W-1:0] LAST_LOC = '1;

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !frozen) |=> (wrPtr == $past(wrPtr) + 1'b1));

  p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !frozen && wrPtr == LAST_LOC) |=> (overflow && wrPtr == '0));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(clearCmd && frozen)) |=> overflow);

  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !clearCmd) |=> $stable(wrPtr));

  p_freeze_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    freezeCmd |=> frozen);

  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (releaseCmd && !freezeCmd) |=> !frozen);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && frozen) |=> (wrPtr == '0 && !overflow && frozen));

  p_clear_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && !frozen && !linkValid) |=> $stable(wrPtr));

  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

endmodule

bind spy_buffer_top spy_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .linkValid(linkValid),
  .freezeCmd(freezeCmd), .releaseCmd(releaseCmd), .clearCmd(clearCmd),
  .rdEn(rdEn), .wrPtr(wrPtr), .overflow(overflow), .frozen(frozen),
  .rdValid(rdValid)
);

// File: tb/sim_spy_buffer_top.sv
`timescale 1ns/1ps
module sim_spy_buffer_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              linkValid = 1'b0;
  logic [DATA_W-1:0] linkData = '0;
  logic              freezeCmd = 1'b0;
  logic              releaseCmd = 1'b0;
  logic              clearCmd = 1'b0;
  logic              rdEn = 1'b0;
  logic              rdSel = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  int nChecks = 0;
  int nFails  = 0;
  string curTag = "R7";

  always #10 clk = ~clk;  // 50 MHz

  spy_buffer_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .linkData(linkData),
    .freezeCmd(freezeCmd), .releaseCmd(releaseCmd), .clearCmd(clearCmd),
    .rdEn(rdEn), .rdSel(rdSel), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid)
  );

  // Reference model state
  int                mPtr;
  bit                mOvf, mFrz;
  logic [DATA_W-1:0] mMem [DEPTH];
  bit                mKnown [DEPTH];
  bit                expValid, expChk;
  logic [DATA_W-1:0] expData;
  string             expTag;

  function automatic logic [DATA_W-1:0] statusWord(int p, bit o, bit f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0] = p[ADDR_W-1:0];
    w[DATA_W-2]   = o;
    w[DATA_W-1]   = f;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pattern(int k);
    return 32'hA5000000 ^ (k * 32'h00010203);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mOvf = 0; mFrz = 0;
      expValid = 0; expChk = 0; expData = '0;
      for (int i = 0; i < DEPTH; i++) mKnown[i] = 0;
    end else begin
      expValid = rdEn;
      expChk   = 0;
      if (rdEn) begin
        if (rdSel) begin
          expData = statusWord(mPtr, mOvf, mFrz); expChk = 1; expTag = curTag;
        end else begin
          expData = mMem[rdAddr]; expChk = mKnown[rdAddr]; expTag = "R6";
        end
      end
      if (!mFrz && linkValid) begin
        mMem[mPtr] = linkData; mKnown[mPtr] = 1;
        if (mPtr == DEPTH-1) mOvf = 1;
        mPtr = (mPtr + 1) % DEPTH;
      end
      if (mFrz && clearCmd) begin mPtr = 0; mOvf = 0; end
      if (freezeCmd) mFrz = 1;
      else if (releaseCmd) mFrz = 0;
    end
  end

  // Output comparison away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      nChecks++;
      if (rdValid !== 1'b0 || rdData !== '0) begin
        nFails++;
        $display("FAIL R1 reset outputs: rdValid=%b rdData=%h expected 0/0", rdValid, rdData);
      end
    end else begin
      nChecks++;
      if (rdValid !== expValid) begin
        nFails++;
        $display("FAIL R8 rdValid=%b expected %b", rdValid, expValid);
      end
      if (expValid && expChk) begin
        nChecks++;
        if (rdData !== expData) begin
          nFails++;
          $display("FAIL %s rdData=%h expected %h", expTag, rdData, expData);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    linkValid = 0; freezeCmd = 0; releaseCmd = 0; clearCmd = 0; rdEn = 0;
  endtask

  task automatic push(logic [DATA_W-1:0] d);
    linkValid = 1; linkData = d; tick();
  endtask

  task automatic readMem(int a);
    rdEn = 1; rdSel = 0; rdAddr = a[ADDR_W-1:0]; tick();
  endtask

  task automatic readStat(string tag);
    curTag = tag; rdEn = 1; rdSel = 1; tick(); tick(); curTag = "R7";
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: status after reset is all zero
    readStat("R1");

    // R2, R6: capture a few words and read them back
    for (int k = 0; k < 5; k++) push(pattern(k));
    readStat("R2");
    for (int k = 0; k < 5; k++) readMem(k);
    tick();

    // R6: read colliding with a write returns the old word (location 5 unwritten -> write 5 first)
    push(pattern(100));                        // location 5
    for (int k = 0; k < DEPTH - 6; k++) push(pattern(200 + k)); // fill to DEPTH-1
    readStat("R3");                            // pointer at 0, overflow set
    linkValid = 1; linkData = 32'hDEAD0000; rdEn = 1; rdSel = 0; rdAddr = 0; tick(); // old pattern(0)
    tick();
    readMem(0);                                // new word
    tick();

    // R3: overflow stays set across further captures
    for (int k = 0; k < 3; k++) push(pattern(300 + k));
    readStat("R3");

    // R4: freeze; traffic ignored, pointer and contents hold
    freezeCmd = 1; linkValid = 1; linkData = pattern(400); tick(); // captured at 4
    for (int k = 0; k < 10; k++) push(32'hBAD00000 + k);
    readStat("R4");
    readMem(4); readMem(5); tick();

    // R5: clear while frozen
    clearCmd = 1; tick();
    readStat("R5");
    // R4: release and resume at held pointer (0)
    releaseCmd = 1; tick();
    push(pattern(500)); push(pattern(501));
    readStat("R4");
    readMem(0); readMem(1); tick();

    // R5: clear ignored while not frozen
    clearCmd = 1; tick();
    readStat("R5");

    // R4: freeze and release in the same cycle -> freeze wins
    freezeCmd = 1; releaseCmd = 1; tick();
    push(32'hBAD1BAD1);
    readStat("R4");
    releaseCmd = 1; tick();

    // R8: back-to-back reads do not disturb state
    for (int k = 0; k < 8; k++) readMem(k);
    readStat("R8");
    readStat("R8");

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      linkValid = ($urandom_range(0, 3) != 0);
      linkData  = $urandom();
      freezeCmd  = (r < 3);
      releaseCmd = (r >= 3 && r < 7);
      clearCmd   = (r >= 7 && r < 10);
      rdEn   = ($urandom_range(0, 1) == 1);
      rdSel  = ($urandom_range(0, 3) == 0);
      rdAddr = ADDR_W'($urandom());
      curTag = "R7";
      @(negedge clk);
    end
    linkValid = 0; freezeCmd = 0; releaseCmd = 0; clearCmd = 0; rdEn = 0;
    tick(); tick();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule